// File: doc/BRIEF.md
# Command Tag Allocator with Cancel Sweep

This block hands out and takes back the command tags that label in-flight transfers on one DMA channel. Free tags are held as a singly linked last-in-first-out list: a head register names the first free tag and each table entry stores the tag that follows it. Each tag also carries an owner word that identifies the request using it. An owner value of zero means the tag is free.

A requester asks for a tag and receives one, or a refusal when none is free, one cycle later. A completion returns a tag. If the tag it names has no owner, the completion is treated as corrupt: a sticky fault is raised and no further completions are accepted. A lookup port reads the owner of any tag. A cancel sweep visits every tag in ascending order. For each tag that still has an owner it emits a cancel event and frees the tag. When the sweep ends it reports how many tags it cancelled. While the sweep runs it has sole use of the table.

Top module: `cmd_tag_pool`

## Requirements
- R1: After reset, `free_cnt` equals NUM_TAGS, `fault` is 0, `alloc_ack` and `sweep_busy` are 0, and every tag's owner reads 0. The free list is ordered 0, 1, ..., NUM_TAGS-1.
- R2: When `alloc_req` is high in a cycle, `alloc_ack` is high in the next cycle. If a tag was free, `alloc_ok` is 1 and `alloc_tag` is the head of the free list; the tag's owner becomes `alloc_owner` and `free_cnt` drops by one. From reset, successive allocations return 0, 1, 2, ...
- R3: With no free tag, an allocation is answered with `alloc_ok`=0 and `alloc_tag` all ones. `free_cnt` and the table do not change.
- R4: A completion (`rel_req`, `rel_tag`) on a tag that has an owner frees the tag, clears its owner to 0 and raises `free_cnt` by one. The most recently freed tag is the next one allocated.
- R5: When a valid completion and an allocation fall in the same cycle, the completion is applied first. The allocation receives the tag just freed, and `free_cnt` does not change.
- R6: A completion that names a tag with owner 0, or a tag at or above NUM_TAGS, sets `fault`. `fault` stays set until reset. While `fault` is set, completions are ignored: no tag is freed and no owner changes. Allocation keeps working.
- R7: A one-cycle `cancel_go` starts a sweep that visits tags 0 to NUM_TAGS-1, one per cycle, in ascending order. For each tag with a nonzero owner it raises `cxl_valid` with that tag and owner, and it frees the tag. At the end it pulses `sweep_done` with `sweep_total` equal to the number of tags cancelled.
- R8: While `sweep_busy` is high, allocations are answered with `alloc_ok`=0, and completions are ignored without raising `fault`.
- R9: `free_cnt` always equals NUM_TAGS minus the number of tags with a nonzero owner. A lookup (`lk_tag`) returns the owner of that tag combinationally, or 0 for a free or out-of-range tag.
- R10: The sweep frees tags in ascending order onto the front of the free list, so the next allocations return the cancelled tags highest first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req | input | 1 | Request a tag |
| alloc_owner | input | OWNER_W | Nonzero owner word to store with the tag |
| alloc_ack | output | 1 | Answer to the request of the previous cycle |
| alloc_ok | output | 1 | A tag was granted |
| alloc_tag | output | TAG_W | Granted tag, all ones on refusal |
| rel_req | input | 1 | Completion returns a tag |
| rel_tag | input | TAG_W | Tag being returned |
| lk_tag | input | TAG_W | Tag to look up |
| lk_owner | output | OWNER_W | Owner of `lk_tag` |
| cancel_go | input | 1 | Start a cancel sweep |
| sweep_busy | output | 1 | Sweep in progress |
| cxl_valid | output | 1 | The tag visited this cycle is cancelled |
| cxl_tag | output | TAG_W | Cancelled tag |
| cxl_owner | output | OWNER_W | Owner of the cancelled tag |
| sweep_done | output | 1 | One-cycle pulse at the end of a sweep |
| sweep_total | output | TAG_W | Number of tags cancelled by the last sweep |
| free_cnt | output | TAG_W | Number of free tags |
| fault | output | 1 | Sticky corrupt-completion flag |

## Verification
The allocator is first driven with a run of allocations from a fresh reset, which shows the initial list order. Completions interleaved with allocations show the last-in-first-out reuse, and a completion and an allocation in the same cycle show the bypass. Allocating until the table is full shows the refusal path, which keeps `free_cnt` unchanged. A sweep over a table in which every other tag is live separates the tags that are cancelled from those that are skipped. Allocations and a completion issued during the sweep show that the sweep holds the table alone. A completion on an already free tag shows the fault, which then blocks a completion on a live tag.

// File: rtl/tag_pool_pkg.sv
package tag_pool_pkg;

    typedef enum logic {
        SWP_IDLE,
        SWP_RUN
    } swp_state_e;

    // tag width leaves room for an all-ones end marker above the last tag
    function automatic int tag_bits(input int n);
        return $clog2(n + 1);
    endfunction

    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/tp_link_store.sv
module tp_link_store #(
    parameter int NUM_TAGS = 255,
    parameter int TAG_W    = 8,
    parameter int IDX_W    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_en,
    input  logic [TAG_W-1:0] push_tag,
    input  logic             pop_en,
    output logic             avail,
    output logic [TAG_W-1:0] avail_tag,
    output logic [TAG_W-1:0] free_cnt
);
    localparam logic [TAG_W-1:0] END_TAG = '1;

    logic [TAG_W-1:0] link_q [NUM_TAGS];
    logic [TAG_W-1:0] head_q;
    logic [TAG_W-1:0] cnt_q;

    // a tag pushed this cycle sits in front of the head
    assign avail_tag = push_en ? push_tag : head_q;
    assign avail     = (avail_tag != END_TAG);
    assign free_cnt  = cnt_q;

    logic [IDX_W-1:0] head_ix, push_ix, avail_ix;
    assign head_ix  = head_q[IDX_W-1:0];
    assign push_ix  = push_tag[IDX_W-1:0];
    assign avail_ix = avail_tag[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_TAGS; i++) begin
                link_q[i] <= (i == NUM_TAGS - 1) ? END_TAG : TAG_W'(i + 1);
            end
            head_q <= '0;
            cnt_q  <= TAG_W'(NUM_TAGS);
        end else begin
            if (pop_en) begin
                link_q[avail_ix] <= END_TAG;
                if (!push_en) begin
                    head_q <= link_q[head_ix];
                end
            end else if (push_en) begin
                link_q[push_ix] <= head_q;
                head_q          <= push_tag;
            end
            case ({push_en, pop_en})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/tp_owner_store.sv
module tp_owner_store #(
    parameter int NUM_TAGS = 255,
    parameter int TAG_W    = 8,
    parameter int IDX_W    = 8,
    parameter int OWNER_W  = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               set_en,
    input  logic [TAG_W-1:0]   set_tag,
    input  logic [OWNER_W-1:0] set_val,
    input  logic               clr_en,
    input  logic [TAG_W-1:0]   clr_tag,
    input  logic [TAG_W-1:0]   rd_a_tag,
    output logic [OWNER_W-1:0] rd_a,
    input  logic [TAG_W-1:0]   rd_b_tag,
    output logic [OWNER_W-1:0] rd_b,
    input  logic [TAG_W-1:0]   rd_c_tag,
    output logic [OWNER_W-1:0] rd_c
);
    logic [OWNER_W-1:0] own_q [NUM_TAGS];

    assign rd_a = (rd_a_tag < TAG_W'(NUM_TAGS)) ? own_q[rd_a_tag[IDX_W-1:0]] : '0;
    assign rd_b = (rd_b_tag < TAG_W'(NUM_TAGS)) ? own_q[rd_b_tag[IDX_W-1:0]] : '0;
    assign rd_c = (rd_c_tag < TAG_W'(NUM_TAGS)) ? own_q[rd_c_tag[IDX_W-1:0]] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_TAGS; i++) begin
                own_q[i] <= '0;
            end
        end else begin
            // set follows clear so a tag freed and regranted keeps the new owner
            if (clr_en) own_q[clr_tag[IDX_W-1:0]] <= '0;
            if (set_en) own_q[set_tag[IDX_W-1:0]] <= set_val;
        end
    end
endmodule

// File: rtl/tp_sweep.sv
module tp_sweep
    import tag_pool_pkg::*;
#(
    parameter int NUM_TAGS = 255,
    parameter int TAG_W    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             hit,
    output logic             busy,
    output logic [TAG_W-1:0] idx,
    output logic             done,
    output logic [TAG_W-1:0] total
);
    localparam logic [TAG_W-1:0] LAST_TAG = TAG_W'(NUM_TAGS - 1);

    swp_state_e       state_q;
    logic [TAG_W-1:0] idx_q, cnt_q, total_q;
    logic             done_q;

    assign busy  = (state_q == SWP_RUN);
    assign idx   = idx_q;
    assign done  = done_q;
    assign total = total_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SWP_IDLE;
            idx_q   <= '0;
            cnt_q   <= '0;
            total_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                SWP_IDLE: begin
                    if (start) begin
                        state_q <= SWP_RUN;
                        idx_q   <= '0;
                        cnt_q   <= '0;
                    end
                end
                SWP_RUN: begin
                    cnt_q <= cnt_q + TAG_W'(hit);
                    if (idx_q == LAST_TAG) begin
                        state_q <= SWP_IDLE;
                        done_q  <= 1'b1;
                        total_q <= cnt_q + TAG_W'(hit);
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: state_q <= SWP_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cmd_tag_pool.sv
module cmd_tag_pool
    import tag_pool_pkg::*;
#(
    parameter int NUM_TAGS = 255,
    parameter int OWNER_W  = 16,
    localparam int TAG_W   = tag_bits(NUM_TAGS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               alloc_req,
    input  logic [OWNER_W-1:0] alloc_owner,
    output logic               alloc_ack,
    output logic               alloc_ok,
    output logic [TAG_W-1:0]   alloc_tag,
    input  logic               rel_req,
    input  logic [TAG_W-1:0]   rel_tag,
    input  logic [TAG_W-1:0]   lk_tag,
    output logic [OWNER_W-1:0] lk_owner,
    input  logic               cancel_go,
    output logic               sweep_busy,
    output logic               cxl_valid,
    output logic [TAG_W-1:0]   cxl_tag,
    output logic [OWNER_W-1:0] cxl_owner,
    output logic               sweep_done,
    output logic [TAG_W-1:0]   sweep_total,
    output logic [TAG_W-1:0]   free_cnt,
    output logic               fault
);
    localparam int               IDX_W   = idx_bits(NUM_TAGS);
    localparam logic [TAG_W-1:0] END_TAG = '1;

    logic [OWNER_W-1:0] own_rel, own_sw;
    logic [TAG_W-1:0]   sw_idx, push_tag, avail_tag;
    logic               sw_hit, push_en, pop_en, avail;
    logic               rel_gate, rel_live, rel_ok, rel_bad;
    logic               fault_q, ack_q, ok_q;
    logic [TAG_W-1:0]   tag_q;

    // completions are arbitrated out during a sweep and after a fault
    assign rel_gate = rel_req && !sweep_busy && !fault_q;
    assign rel_live = (rel_tag < TAG_W'(NUM_TAGS)) && (own_rel != '0);
    assign rel_ok   = rel_gate && rel_live;
    assign rel_bad  = rel_gate && !rel_live;

    assign sw_hit   = sweep_busy && (own_sw != '0);
    assign push_en  = rel_ok || sw_hit;
    assign push_tag = sweep_busy ? sw_idx : rel_tag;
    assign pop_en   = alloc_req && !sweep_busy && avail;

    tp_link_store #(
        .NUM_TAGS (NUM_TAGS),
        .TAG_W    (TAG_W),
        .IDX_W    (IDX_W)
    ) u_links (
        .clk       (clk),
        .rst       (rst),
        .push_en   (push_en),
        .push_tag  (push_tag),
        .pop_en    (pop_en),
        .avail     (avail),
        .avail_tag (avail_tag),
        .free_cnt  (free_cnt)
    );

    tp_owner_store #(
        .NUM_TAGS (NUM_TAGS),
        .TAG_W    (TAG_W),
        .IDX_W    (IDX_W),
        .OWNER_W  (OWNER_W)
    ) u_owners (
        .clk      (clk),
        .rst      (rst),
        .set_en   (pop_en),
        .set_tag  (avail_tag),
        .set_val  (alloc_owner),
        .clr_en   (push_en),
        .clr_tag  (push_tag),
        .rd_a_tag (rel_tag),
        .rd_a     (own_rel),
        .rd_b_tag (sw_idx),
        .rd_b     (own_sw),
        .rd_c_tag (lk_tag),
        .rd_c     (lk_owner)
    );

    tp_sweep #(
        .NUM_TAGS (NUM_TAGS),
        .TAG_W    (TAG_W)
    ) u_sweep (
        .clk   (clk),
        .rst   (rst),
        .start (cancel_go),
        .hit   (sw_hit),
        .busy  (sweep_busy),
        .idx   (sw_idx),
        .done  (sweep_done),
        .total (sweep_total)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_q <= 1'b0;
            ack_q   <= 1'b0;
            ok_q    <= 1'b0;
            tag_q   <= END_TAG;
        end else begin
            fault_q <= fault_q || rel_bad;
            ack_q   <= alloc_req;
            ok_q    <= pop_en;
            tag_q   <= pop_en ? avail_tag : END_TAG;
        end
    end

    assign alloc_ack = ack_q;
    assign alloc_ok  = ok_q;
    assign alloc_tag = tag_q;
    assign fault     = fault_q;
    assign cxl_valid = sw_hit;
    assign cxl_tag   = sw_idx;
    assign cxl_owner = own_sw;
endmodule

// File: rtl/cmd_tag_pool_chk.sv
module cmd_tag_pool_chk
    import tag_pool_pkg::*;
#(
    parameter int NUM_TAGS = 255,
    parameter int OWNER_W  = 16,
    localparam int TAG_W   = tag_bits(NUM_TAGS)
) (
    input logic             clk,
    input logic             rst,
    input logic             alloc_req,
    input logic             alloc_ack,
    input logic             alloc_ok,
    input logic             rel_req,
    input logic             sweep_busy,
    input logic             cxl_valid,
    input logic             sweep_done,
    input logic [TAG_W-1:0] free_cnt,
    input logic             fault
);
    assert_ack_next_R2: assert property (@(posedge clk) disable iff (rst)
        alloc_req |=> alloc_ack);

    assert_grant_takes_one_R2: assert property (@(posedge clk) disable iff (rst)
        (alloc_req && !rel_req && !sweep_busy && free_cnt != '0)
        |=> (alloc_ok && free_cnt == $past(free_cnt) - 1'b1));

    assert_no_grant_empty_R3: assert property (@(posedge clk) disable iff (rst)
        (alloc_req && !rel_req && !sweep_busy && free_cnt == '0)
        |=> (!alloc_ok && free_cnt == '0));

    assert_fault_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        fault |=> fault);

    assert_cancel_frees_R7: assert property (@(posedge clk) disable iff (rst)
        cxl_valid |=> (free_cnt == $past(free_cnt) + 1'b1));

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
        sweep_done |-> !sweep_busy);

    assert_sweep_blocks_R8: assert property (@(posedge clk) disable iff (rst)
        (sweep_busy && alloc_req) |=> (alloc_ack && !alloc_ok));

    assert_sweep_no_fault_R8: assert property (@(posedge clk) disable iff (rst)
        (sweep_busy && !fault) |=> !fault);

    assert_count_bound_R9: assert property (@(posedge clk) disable iff (rst)
        free_cnt <= TAG_W'(NUM_TAGS));
endmodule

bind cmd_tag_pool cmd_tag_pool_chk #(
    .NUM_TAGS (NUM_TAGS),
    .OWNER_W  (OWNER_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .alloc_req  (alloc_req),
    .alloc_ack  (alloc_ack),
    .alloc_ok   (alloc_ok),
    .rel_req    (rel_req),
    .sweep_busy (sweep_busy),
    .cxl_valid  (cxl_valid),
    .sweep_done (sweep_done),
    .free_cnt   (free_cnt),
    .fault      (fault)
);

// File: tb/tb_cmd_tag_pool.sv
`timescale 1ns/1ps
module tb_cmd_tag_pool;
    localparam int N  = 8;
    localparam int OW = 16;
    localparam int TW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          alloc_req = 1'b0;
    logic [OW-1:0] alloc_owner = '0;
    logic          alloc_ack, alloc_ok;
    logic [TW-1:0] alloc_tag;
    logic          rel_req = 1'b0;
    logic [TW-1:0] rel_tag = '0;
    logic [TW-1:0] lk_tag = '0;
    logic [OW-1:0] lk_owner;
    logic          cancel_go = 1'b0;
    logic          sweep_busy, cxl_valid, sweep_done, fault;
    logic [TW-1:0] cxl_tag, sweep_total, free_cnt;
    logic [OW-1:0] cxl_owner;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    cmd_tag_pool #(.NUM_TAGS(N), .OWNER_W(OW)) dut (
        .clk(clk), .rst(rst),
        .alloc_req(alloc_req), .alloc_owner(alloc_owner),
        .alloc_ack(alloc_ack), .alloc_ok(alloc_ok), .alloc_tag(alloc_tag),
        .rel_req(rel_req), .rel_tag(rel_tag),
        .lk_tag(lk_tag), .lk_owner(lk_owner),
        .cancel_go(cancel_go), .sweep_busy(sweep_busy),
        .cxl_valid(cxl_valid), .cxl_tag(cxl_tag), .cxl_owner(cxl_owner),
        .sweep_done(sweep_done), .sweep_total(sweep_total),
        .free_cnt(free_cnt), .fault(fault)
    );

    typedef struct packed {
        logic [1:0]    op;   // 1 allocate, 2 complete, 3 both
        logic [OW-1:0] own;
        logic [TW-1:0] rtag;
        logic          ok;
        logic [TW-1:0] tag;
        logic [TW-1:0] fr;
    } vec_t;

    localparam vec_t VEC [11] = '{
        '{2'd1, 16'h0011, 4'd0, 1'b1, 4'd0, 4'd7},
        '{2'd1, 16'h0022, 4'd0, 1'b1, 4'd1, 4'd6},
        '{2'd1, 16'h0033, 4'd0, 1'b1, 4'd2, 4'd5},
        '{2'd2, 16'h0000, 4'd1, 1'b0, 4'd0, 4'd6},
        '{2'd1, 16'h0044, 4'd0, 1'b1, 4'd1, 4'd5},
        '{2'd3, 16'h0055, 4'd0, 1'b1, 4'd0, 4'd5},
        '{2'd2, 16'h0000, 4'd2, 1'b0, 4'd0, 4'd6},
        '{2'd2, 16'h0000, 4'd0, 1'b0, 4'd0, 4'd7},
        '{2'd1, 16'h0066, 4'd0, 1'b1, 4'd0, 4'd6},
        '{2'd1, 16'h0077, 4'd0, 1'b1, 4'd2, 4'd5},
        '{2'd1, 16'h0088, 4'd0, 1'b1, 4'd3, 4'd4}
    };

    // cancel event recorder
    logic          rec_on = 1'b0;
    int            rec_n  = 0;
    logic [TW-1:0] rec_tag [8];
    logic [OW-1:0] rec_own [8];

    always @(negedge clk) begin
        if (rec_on && cxl_valid && rec_n < 8) begin
            rec_tag[rec_n] = cxl_tag;
            rec_own[rec_n] = cxl_owner;
            rec_n = rec_n + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_alloc(input logic [OW-1:0] own);
        alloc_req = 1'b1; alloc_owner = own;
        tick();
        alloc_req = 1'b0;
    endtask

    task automatic do_rel(input logic [TW-1:0] t);
        rel_req = 1'b1; rel_tag = t;
        tick();
        rel_req = 1'b0;
    endtask

    task automatic look(input string req, input logic [TW-1:0] t, input logic [OW-1:0] exp);
        lk_tag = t;
        #1;
        chk(req, 32'(lk_owner), 32'(exp));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 free_cnt", 32'(free_cnt), N);
        chk("R1 fault", 32'(fault), 0);
        chk("R1 alloc_ack", 32'(alloc_ack), 0);
        chk("R1 sweep_busy", 32'(sweep_busy), 0);
        look("R1 owner tag0", 4'd0, 16'h0);

        // vector walk: allocations, completions, same-cycle pairs
        for (int i = 0; i < 11; i++) begin
            string lbl;
            lbl = (VEC[i].op == 2'd3) ? "R5" : (VEC[i].op == 2'd2) ? "R4" : "R2";
            alloc_req   = VEC[i].op[0];
            alloc_owner = VEC[i].own;
            rel_req     = VEC[i].op[1];
            rel_tag     = VEC[i].rtag;
            tick();
            alloc_req = 1'b0;
            rel_req   = 1'b0;
            chk({lbl, " ack"}, 32'(alloc_ack), 32'(VEC[i].op[0]));
            if (VEC[i].op[0]) begin
                chk({lbl, " ok"}, 32'(alloc_ok), 32'(VEC[i].ok));
                chk({lbl, " tag"}, 32'(alloc_tag), 32'(VEC[i].tag));
            end
            chk({lbl, " free_cnt"}, 32'(free_cnt), 32'(VEC[i].fr));
        end

        look("R2 owner tag1", 4'd1, 16'h0044);
        look("R2 owner tag3", 4'd3, 16'h0088);
        look("R9 free tag5 owner", 4'd5, 16'h0);

        // fill the table
        for (int t = 4; t < 8; t++) begin
            do_alloc(16'h00A0 + 16'(t));
            chk("R2 fill tag", 32'(alloc_tag), t);
        end
        chk("R9 free_cnt full", 32'(free_cnt), 0);
        do_alloc(16'h0099);
        chk("R3 empty ack", 32'(alloc_ack), 1);
        chk("R3 empty ok", 32'(alloc_ok), 0);
        chk("R3 empty tag", 32'(alloc_tag), 15);
        chk("R3 free_cnt kept", 32'(free_cnt), 0);

        // free odd tags, leave 0,2,4,6 live
        do_rel(4'd1); do_rel(4'd3); do_rel(4'd5); do_rel(4'd7);
        chk("R4 free_cnt", 32'(free_cnt), 4);
        look("R4 owner cleared", 4'd7, 16'h0);

        // sweep with competing traffic in its first cycle
        rec_on = 1'b1;
        cancel_go = 1'b1;
        tick();
        cancel_go = 1'b0;
        chk("R7 busy", 32'(sweep_busy), 1);
        alloc_req = 1'b1; alloc_owner = 16'h0099;
        rel_req = 1'b1; rel_tag = 4'd2;
        tick();
        alloc_req = 1'b0; rel_req = 1'b0;
        chk("R8 alloc ack", 32'(alloc_ack), 1);
        chk("R8 alloc refused", 32'(alloc_ok), 0);
        for (int w = 0; w < 20 && !sweep_done; w++) tick();
        rec_on = 1'b0;
        chk("R7 done", 32'(sweep_done), 1);
        chk("R7 total", 32'(sweep_total), 4);
        chk("R7 events", rec_n, 4);
        chk("R7 ev0 tag", 32'(rec_tag[0]), 0);
        chk("R7 ev0 owner", 32'(rec_own[0]), 32'h66);
        chk("R7 ev1 tag", 32'(rec_tag[1]), 2);
        chk("R7 ev1 owner", 32'(rec_own[1]), 32'h77);
        chk("R7 ev2 tag", 32'(rec_tag[2]), 4);
        chk("R7 ev3 tag", 32'(rec_tag[3]), 6);
        chk("R7 ev3 owner", 32'(rec_own[3]), 32'hA6);
        chk("R7 free_cnt", 32'(free_cnt), N);
        chk("R8 no fault", 32'(fault), 0);
        look("R7 owner freed", 4'd0, 16'h0);

        // LIFO after sweep
        do_alloc(16'h0031);
        chk("R10 first tag", 32'(alloc_tag), 6);
        do_alloc(16'h0032);
        chk("R10 second tag", 32'(alloc_tag), 4);

        // corrupt completion
        do_rel(4'd5);
        chk("R6 fault set", 32'(fault), 1);
        chk("R6 free_cnt kept", 32'(free_cnt), 6);
        do_rel(4'd6);
        chk("R6 masked free_cnt", 32'(free_cnt), 6);
        look("R6 masked owner", 4'd6, 16'h0031);
        do_alloc(16'h0033);
        chk("R6 alloc ok", 32'(alloc_ok), 1);
        chk("R6 alloc tag", 32'(alloc_tag), 2);
        chk("R6 fault stays", 32'(fault), 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule